// File: doc/BRIEF.md
# Periodic Rate, Square-Wave and Interrupt Status Unit

This unit sits beside a real-time clock's calendar counters. It runs a 15-stage binary divider, advancing once per pulse of a 32.768 kHz clock enable. A 4-bit rate code picks one divider bit as a tap. That tap drives a gated square-wave output and raises a periodic-event flag on each of its rising edges. The same divider yields an update-in-progress window that opens a fixed number of ticks before the once-per-second rollover.

The unit also keeps the interrupt status byte. This byte holds three event flags: periodic, alarm and update-ended. The alarm and update-ended events come in as single-cycle pulses from elsewhere. Each flag is combined with its enable to form an interrupt summary bit. That bit drives an output-enable for an active-low, open-drain request line, whose data level is always low. A status read is presented as a level strobe for as long as the read lasts. While it is high the byte holds still and new events are parked. The flags clear on the cycle after the strobe drops, and any parked events are applied at that moment.

Top module: `rtc_rate_irq`

## Requirements
- R1: The divider counter advances by one on each cycle with `tick_en` high. Rate codes 1 and 2 select counter bits 6 and 7 (256 Hz and 128 Hz at a 32.768 kHz tick). Codes 3 to 15 select bit `code-2`, giving 65536/2^code Hz.
- R2: With rate code 0, `sqw_o` stays low and the periodic flag is never set, whatever the enables are.
- R3: `sqw_o` is the selected counter bit after the tick, registered, and gated by the square-wave enable. When that enable is 0 the output is held low.
- R4: The periodic flag (status bit 6) is set on each rising edge of the selected bit, whether or not its enable is set.
- R5: A pulse on `alarm_evt` sets the alarm flag (status bit 5). A pulse on `update_evt` sets the update-ended flag (status bit 4).
- R6: `stat_data` is {IRQF, PF, AF, UF, 4'b0000}, where IRQF = PF&PIE | AF&AIE | UF&UIE.
- R7: `irq_oe` equals IRQF. `irq_o` is always 0. Writing an enable while its flag is already 1 asserts `irq_oe` on the next cycle.
- R8: While `stat_rd` is high, `stat_data` holds still and incoming events are parked. On the first cycle after `stat_rd` falls, all flags are cleared and only the parked events (plus any event in that cycle) remain.
- R9: Synchronous reset clears PIE, AIE, UIE, the square-wave enable and all flags, and releases `irq_oe`. The rate code is an input and is not affected by reset.
- R10: `uip_o` is high for the last 8 ticks before the divider wraps (about 244 µs), and reads 0 while `set_mode` is 1.
- R11: While `set_mode` is 1, UIE is cleared and writes to UIE have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32.768 kHz clock enable for the divider |
| rate_code | input | 4 | Tap select; 0 disables |
| set_mode | input | 1 | Update-inhibit mode; clears UIE, forces UIP low |
| cfg_we | input | 1 | Write strobe for the enable bits |
| cfg_pie | input | 1 | Periodic interrupt enable value |
| cfg_aie | input | 1 | Alarm interrupt enable value |
| cfg_uie | input | 1 | Update-ended interrupt enable value |
| cfg_sqwe | input | 1 | Square-wave output enable value |
| alarm_evt | input | 1 | Single-cycle alarm event |
| update_evt | input | 1 | Single-cycle update-ended event |
| stat_rd | input | 1 | Status read in progress (level) |
| sqw_o | output | 1 | Square-wave output |
| uip_o | output | 1 | Update-in-progress status |
| stat_data | output | 8 | Interrupt status byte |
| irq_oe | output | 1 | Drive enable for the interrupt line |
| irq_o | output | 1 | Interrupt line data level (always low) |

## Verification
The hardest case to reach is an event that lands inside a status read. The read must return an unchanged byte while the event is parked, and the event must then reappear alone once the read ends. The stimulus creates this directly. It first raises an alarm flag and enables it. It then holds `stat_rd` high across an update pulse and checks the byte on each side of the strobe's falling edge. The update-in-progress window only opens near a divider wrap, so the stimulus runs the tick continuously through a full 32768-tick second twice: once to measure the window, and once under `set_mode` to confirm the window stays closed.

// File: rtl/rate_irq_pkg.sv
package rate_irq_pkg;
  // Flag positions inside the 3-bit flag/enable vectors (PF, AF, UF order)
  localparam int FL_PER = 2;
  localparam int FL_ALM = 1;
  localparam int FL_UPD = 0;
  localparam int FL_N   = 3;

  // Map a rate code to the divider bit that serves as its tap
  function automatic int unsigned tap_of(input logic [3:0] code);
    case (code)
      4'd1:    tap_of = 6;
      4'd2:    tap_of = 7;
      default: tap_of = (code >= 4'd2) ? int'(code) - 2 : 0;
    endcase
  endfunction
endpackage

// File: rtl/rate_divider.sv
module rate_divider
  import rate_irq_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              cfg_we,
  input  logic              cfg_sqwe,
  output logic [STAGES-1:0] cnt_next,
  output logic              per_evt,
  output logic              sqw_o
);
  logic [STAGES-1:0] cnt_q;
  logic              sqwe_q;
  logic              sqwe_n;
  logic              code_on;
  int unsigned       tap;

  assign cnt_next = tick_en ? cnt_q + 1'b1 : cnt_q;
  assign code_on  = (rate_code != '0);
  assign tap      = tap_of(rate_code[3:0]);
  assign sqwe_n   = cfg_we ? cfg_sqwe : sqwe_q;
  assign per_evt  = tick_en && code_on && !cnt_q[tap] && cnt_next[tap];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sqwe_q <= 1'b0;
      sqw_o  <= 1'b0;
    end else begin
      cnt_q  <= cnt_next;
      sqwe_q <= sqwe_n;
      sqw_o  <= sqwe_n && code_on && cnt_next[tap];
    end
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r1_count_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt_q));
  a_r2_code_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (rate_code == '0) |-> !per_evt);
  a_r3_sqw_gated: assert property (@(posedge clk) disable iff (rst)
    (!sqwe_q && !cfg_we) |=> !sqw_o);
endmodule

// File: rtl/uip_window.sv
module uip_window #(
  parameter int STAGES = 15,
  parameter int WIN    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_mode,
  input  logic [STAGES-1:0] cnt_next,
  output logic              uip_o
);
  localparam logic [STAGES-1:0] OPEN_AT = STAGES'((1 << STAGES) - WIN);

  always_ff @(posedge clk) begin
    if (rst) uip_o <= 1'b0;
    else     uip_o <= !set_mode && (cnt_next >= OPEN_AT);
  end

  a_r10_set_closes: assert property (@(posedge clk) disable iff (rst)
    set_mode |=> !uip_o);
endmodule

// File: rtl/irq_status.sv
module irq_status
  import rate_irq_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              per_evt,
  input  logic              alarm_evt,
  input  logic              update_evt,
  input  logic              stat_rd,
  input  logic              set_mode,
  input  logic              cfg_we,
  input  logic              cfg_pie,
  input  logic              cfg_aie,
  input  logic              cfg_uie,
  output logic [STAT_W-1:0] stat_data,
  output logic              irq_oe
);
  localparam int PAD_W = STAT_W - FL_N - 1;

  logic [FL_N-1:0] flags_q, pend_q, en_q, evt;
  logic            rd_q;
  logic            irqf;

  assign evt = {per_evt, alarm_evt, update_evt};

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      pend_q  <= '0;
      en_q    <= '0;
      rd_q    <= 1'b0;
    end else begin
      rd_q <= stat_rd;
      if (stat_rd) begin
        pend_q <= pend_q | evt;
      end else if (rd_q) begin
        flags_q <= pend_q | evt;
        pend_q  <= '0;
      end else begin
        flags_q <= flags_q | evt;
      end
      if (cfg_we) begin
        en_q[FL_PER] <= cfg_pie;
        en_q[FL_ALM] <= cfg_aie;
      end
      if (set_mode)    en_q[FL_UPD] <= 1'b0;
      else if (cfg_we) en_q[FL_UPD] <= cfg_uie;
    end
  end

  assign irqf      = |(flags_q & en_q);
  assign irq_oe    = irqf;
  assign stat_data = {irqf, flags_q, {PAD_W{1'b0}}};

  a_r8_hold_during_read: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> $stable(flags_q));
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (flags_q == '0) && (en_q == '0) && !irq_oe);
  a_r11_set_kills_uie: assert property (@(posedge clk) disable iff (rst)
    set_mode |=> !en_q[FL_UPD]);
  a_r5_alarm_sets: assert property (@(posedge clk) disable iff (rst)
    (alarm_evt && !stat_rd && !rd_q) |=> flags_q[FL_ALM]);
endmodule

// File: rtl/rtc_rate_irq.sv
module rtc_rate_irq #(
  parameter int STAGES = 15,
  parameter int CODE_W = 4,
  parameter int UIP_WIN = 8,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              set_mode,
  input  logic              cfg_we,
  input  logic              cfg_pie,
  input  logic              cfg_aie,
  input  logic              cfg_uie,
  input  logic              cfg_sqwe,
  input  logic              alarm_evt,
  input  logic              update_evt,
  input  logic              stat_rd,
  output logic              sqw_o,
  output logic              uip_o,
  output logic [STAT_W-1:0] stat_data,
  output logic              irq_oe,
  output logic              irq_o
);
  logic [STAGES-1:0] cnt_next;
  logic              per_evt;

  rate_divider #(.STAGES(STAGES), .CODE_W(CODE_W)) u_div (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rate_code(rate_code),
    .cfg_we(cfg_we), .cfg_sqwe(cfg_sqwe),
    .cnt_next(cnt_next), .per_evt(per_evt), .sqw_o(sqw_o)
  );

  uip_window #(.STAGES(STAGES), .WIN(UIP_WIN)) u_uip (
    .clk(clk), .rst(rst), .set_mode(set_mode), .cnt_next(cnt_next), .uip_o(uip_o)
  );

  irq_status #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst(rst), .per_evt(per_evt), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .stat_rd(stat_rd), .set_mode(set_mode),
    .cfg_we(cfg_we), .cfg_pie(cfg_pie), .cfg_aie(cfg_aie), .cfg_uie(cfg_uie),
    .stat_data(stat_data), .irq_oe(irq_oe)
  );

  // Open-drain style: the line is only ever pulled low
  assign irq_o = 1'b0;

  a_r7_line_never_high: assert property (@(posedge clk) disable iff (rst)
    irq_oe |-> !irq_o);
endmodule

// File: tb/test_rtc_rate_irq.sv
`timescale 1ns/1ps
module test_rtc_rate_irq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic set_mode = 1'b0, cfg_we = 1'b0;
  logic cfg_pie = 1'b0, cfg_aie = 1'b0, cfg_uie = 1'b0, cfg_sqwe = 1'b0;
  logic alarm_evt = 1'b0, update_evt = 1'b0, stat_rd = 1'b0;
  logic sqw_o, uip_o, irq_oe, irq_o;
  logic [7:0] stat_data;

  int checks = 0, errors = 0;
  int tick_mode = 0, phase = 0;
  bit done = 0, started = 0;

  always #2.5 clk = ~clk;

  rtc_rate_irq i_rtc_rate_irq (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rate_code(rate_code),
    .set_mode(set_mode), .cfg_we(cfg_we), .cfg_pie(cfg_pie), .cfg_aie(cfg_aie),
    .cfg_uie(cfg_uie), .cfg_sqwe(cfg_sqwe), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .stat_rd(stat_rd), .sqw_o(sqw_o), .uip_o(uip_o),
    .stat_data(stat_data), .irq_oe(irq_oe), .irq_o(irq_o)
  );

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_pf, m_af, m_uf, p_pf, p_af, p_uf;
  int m_pie, m_aie, m_uie, m_sqwe, m_sqw, m_uip, m_rdq;

  function automatic int tap_for(input int code);
    if (code == 1) return 6;
    if (code == 2) return 7;
    return code - 2;
  endfunction

  function automatic int bit_at(input int v, input int b);
    return (v >> b) & 1;
  endfunction

  always @(posedge clk) begin
    int nc, tp, pe;
    if (rst) begin
      m_cnt = 0; m_pf = 0; m_af = 0; m_uf = 0; p_pf = 0; p_af = 0; p_uf = 0;
      m_pie = 0; m_aie = 0; m_uie = 0; m_sqwe = 0; m_sqw = 0; m_uip = 0; m_rdq = 0;
    end else begin
      nc = tick_en ? (m_cnt + 1) % 32768 : m_cnt;
      tp = tap_for(int'(rate_code));
      pe = (tick_en && rate_code != 0 && bit_at(m_cnt, tp) == 0 && bit_at(nc, tp) == 1) ? 1 : 0;
      if (stat_rd) begin
        p_pf = p_pf | pe; p_af = p_af | int'(alarm_evt); p_uf = p_uf | int'(update_evt);
      end else if (m_rdq != 0) begin
        m_pf = p_pf | pe; m_af = p_af | int'(alarm_evt); m_uf = p_uf | int'(update_evt);
        p_pf = 0; p_af = 0; p_uf = 0;
      end else begin
        m_pf = m_pf | pe; m_af = m_af | int'(alarm_evt); m_uf = m_uf | int'(update_evt);
      end
      if (cfg_we) begin m_pie = int'(cfg_pie); m_aie = int'(cfg_aie); m_sqwe = int'(cfg_sqwe); end
      if (set_mode) m_uie = 0; else if (cfg_we) m_uie = int'(cfg_uie);
      m_sqw = (m_sqwe != 0 && rate_code != 0 && bit_at(nc, tp) == 1) ? 1 : 0;
      m_uip = (!set_mode && nc >= 32768 - 8) ? 1 : 0;
      m_cnt = nc;
      m_rdq = int'(stat_rd);
    end
    started = 1;
  end

  function automatic int exp_irqf();
    return (m_pf & m_pie) | (m_af & m_aie) | (m_uf & m_uie);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      check("R3 sqw", int'(sqw_o), m_sqw);
      check("R10 uip", int'(uip_o), m_uip);
      check("R6 status", int'(stat_data), (exp_irqf() << 7) | (m_pf << 6) | (m_af << 5) | (m_uf << 4));
      check("R7 irq_oe", int'(irq_oe), exp_irqf());
      check("R7 irq_o", int'(irq_o), 0);
    end
  end

  // tick generator
  always @(negedge clk) begin
    if (tick_mode == 0) tick_en <= 1'b1;
    else begin
      tick_en <= (phase != 2);
      phase = (phase + 1) % 3;
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input bit pie, input bit aie, input bit uie, input bit sqwe);
    cfg_pie = pie; cfg_aie = aie; cfg_uie = uie; cfg_sqwe = sqwe; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_read();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic sqw_period(output int p);
    int t0 = 0, n = 0;
    while (sqw_o !== 1'b0 && n < 40000) begin @(negedge clk); n++; end
    while (sqw_o !== 1'b1 && n < 40000) begin @(negedge clk); n++; end
    t0 = n;
    while (sqw_o !== 1'b0 && n < 40000) begin @(negedge clk); n++; end
    while (sqw_o !== 1'b1 && n < 40000) begin @(negedge clk); n++; end
    p = n - t0;
  endtask

  initial begin
    int p, hi, n;
    bit seen;
    cyc(3);
    rst = 1'b0;
    // R9: reset state
    check("R9 reset status", int'(stat_data), 0);
    check("R9 reset irq", int'(irq_oe), 0);
    check("R9 reset sqw", int'(sqw_o), 0);

    // R1/R3: tap periods with a tick every cycle
    tick_mode = 0;
    write_cfg(0, 0, 0, 1);
    rate_code = 4'd1; sqw_period(p); check("R1 code1 period", p, 128);
    rate_code = 4'd2; sqw_period(p); check("R1 code2 period", p, 256);
    rate_code = 4'd3; sqw_period(p); check("R1 code3 period", p, 4);
    rate_code = 4'd6; sqw_period(p); check("R1 code6 period", p, 32);

    // R3: enable off holds output low
    write_cfg(0, 0, 0, 0);
    seen = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (sqw_o) seen = 1; end
    check("R3 sqw held low", int'(seen), 0);

    // R4: periodic flag without its enable
    do_read();
    rate_code = 4'd3;
    cyc(10);
    check("R4 pf set", int'(stat_data[6]), 1);
    check("R4 no irq without pie", int'(irq_oe), 0);
    // R7: enabling with flag already set
    write_cfg(1, 0, 0, 0);
    check("R7 immediate irq", int'(irq_oe), 1);

    // R2: code zero is silent
    rate_code = 4'd0;
    write_cfg(1, 0, 0, 1);
    do_read();
    seen = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (sqw_o || stat_data[6]) seen = 1; end
    check("R2 code0 silent", int'(seen), 0);

    // R5/R8: event during a read is parked
    write_cfg(0, 0, 0, 0);
    alarm_evt = 1'b1; @(negedge clk); alarm_evt = 1'b0; @(negedge clk);
    check("R5 alarm flag", int'(stat_data), 'h20);
    write_cfg(0, 1, 0, 0);
    check("R7 alarm irq", int'(irq_oe), 1);
    stat_rd = 1'b1; @(negedge clk);
    check("R8 read value", int'(stat_data), 'hA0);
    update_evt = 1'b1; @(negedge clk); update_evt = 1'b0;
    check("R8 stable during read", int'(stat_data), 'hA0);
    @(negedge clk);
    stat_rd = 1'b0; @(negedge clk);
    check("R8 parked event only", int'(stat_data), 'h10);
    check("R8 irq released", int'(irq_oe), 0);

    // R11: SET clears UIE and blocks writes
    write_cfg(0, 0, 1, 0);
    check("R5 update irq", int'(stat_data), 'h90);
    set_mode = 1'b1; @(negedge clk);
    check("R11 uie cleared", int'(irq_oe), 0);
    write_cfg(0, 0, 1, 0);
    check("R11 uie write ignored", int'(stat_data), 'h10);
    set_mode = 1'b0;
    write_cfg(0, 0, 1, 0);
    check("R11 uie after release", int'(irq_oe), 1);

    // R9: reset mid-run keeps the rate code
    rate_code = 4'd3;
    write_cfg(1, 1, 1, 1);
    alarm_evt = 1'b1; @(negedge clk); alarm_evt = 1'b0;
    rst = 1'b1; cyc(2); rst = 1'b0;
    check("R9 flags cleared", int'(stat_data), 0);
    check("R9 irq released", int'(irq_oe), 0);
    check("R9 sqw disabled", int'(sqw_o), 0);
    write_cfg(0, 0, 0, 1);
    sqw_period(p); check("R9 rate code kept", p, 4);

    // Sweep every code with gapped ticks; model compares each cycle
    tick_mode = 1;
    write_cfg(1, 0, 0, 1);
    for (int c = 0; c < 16; c++) begin
      rate_code = 4'(c);
      cyc(200);
      do_read();
    end
    tick_mode = 0;

    // R10: update-in-progress window length
    rate_code = 4'd0;
    n = 0;
    while (uip_o !== 1'b1 && n < 40000) begin @(negedge clk); n++; end
    hi = 0;
    while (uip_o === 1'b1 && hi < 100) begin @(negedge clk); hi++; end
    check("R10 window ticks", hi, 8);
    set_mode = 1'b1;
    seen = 0;
    for (int i = 0; i < 33000; i++) begin @(negedge clk); if (uip_o) seen = 1; end
    check("R10 closed under set", int'(seen), 0);
    set_mode = 1'b0;
    cyc(4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule